// File: doc/BRIEF.md
# One-Time-Programmable Security Register Command Controller

This block is the command front end of a 128-bit one-time-programmable security register held inside a word-wide parallel flash device. The register holds a 64-bit factory identity, which is fixed, and a 64-bit user segment, plus a 16-bit lock word. A host talks to it through plain bus write and read cycles. Command codes arrive on the low data byte. A two-write program sequence stores 16 bits at a time into the register.

Programming can only clear bits, so each stored word becomes the old word AND the written data. The lock word has two bits that gate the two segments. Both of them are one-way. Any program that goes out of range or hits a locked segment leaves a sticky error code in a status byte, which the host reads back in status mode. Each program holds the ready flag low for a fixed number of cycles. While ready is low the controller ignores writes.

Top module: `otp_sec_ctrl`

## Requirements
- R1: After reset the controller is in array mode, the lock word reads FFFEh, every user word reads FFFFh and the status byte is 80h with no error bits set.
- R2: In array mode every read returns FFFFh whatever the address, and writing command FFh (low data byte) returns the controller to array mode.
- R3: Writing command 90h enters identification mode. The word address is addr[8:1], and addr[0] is ignored for both reads and programs. In this mode a read of word 80h returns the lock word, 81h to 84h return the factory value (81h holds bits 15:0 of FACTORY_ID, 84h holds bits 63:48), 85h to 88h return the user words, and any other word returns 0000h.
- R4: Writing command C0h arms a program. The next write programs the addressed word with stored = old AND wdata. Both writes leave the controller in status mode, where reads return the status byte.
- R5: The status byte sits on rdata[7:0], with rdata[15:8] = 0. Bit 7 is ready, bit 4 is program error, bit 1 is lock error, and the other bits are 0. A program aimed outside words 80h to 88h sets bit 4 only and changes no stored word.
- R6: A program aimed at a locked segment sets bits 4 and 1 and changes no stored word. The factory segment is always locked.
- R7: Programming FFFDh to word 80h clears lock bit 1, which locks the user segment. Lock bits never return to 1, and the lock word itself stays programmable.
- R8: After the program write, status bit 7 reads 0 for PROG_CYCLES cycles. Any write made while bit 7 is 0 is ignored.
- R9: The error bits stay set until command 50h is written. That command clears both error bits and leaves the mode unchanged.
- R10: rdata is registered, and rd_valid is high in the cycle after each rd_en. Command codes that are not recognised have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read cycle strobe |
| addr | input | ADDR_W | Bus address; bits [ADDR_W-1:1] form the word address |
| wdata | input | 16 | Write data; the command code sits in bits 7:0 |
| rd_valid | output | 1 | rdata holds the result of the previous read cycle |
| rdata | output | 16 | Registered read data |

## Verification
The bench goes after the corner cases first. These are a read taken straight after a program, while ready is low, and a mode command written during that busy window. A design with the wrong busy length would show bit 7 early, and a design that accepted writes while busy would jump to identification mode. Programs aimed out of range, at the factory words and at a locked user word have to leave the stored data intact and raise the right pair of error bits. A design that shared one error path would raise the lock error for range faults. A second program to the same user word and a rewrite of the lock word with FFFFh catch a design that overwrites bits instead of clearing them, which would let a lock be reversed. Error bits are read again after mode changes and after 50h, so that a design that cleared them on the wrong command, or changed mode on 50h, shows up.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_IDENT, M_STATUS, M_SETUP} mode_e;
  typedef enum logic [1:0] {RG_NONE, RG_LOCK, RG_FACT, RG_USER} region_e;

  localparam int WORD_W    = 16;
  localparam int CMD_W     = 8;
  localparam int SEG_WORDS = 4;

  localparam logic [CMD_W-1:0] CMD_IDENT = 8'h90;
  localparam logic [CMD_W-1:0] CMD_ARRAY = 8'hFF;
  localparam logic [CMD_W-1:0] CMD_SETUP = 8'hC0;
  localparam logic [CMD_W-1:0] CMD_CLRSR = 8'h50;

  localparam int WA_LOCK  = 'h80;
  localparam int WA_FACT0 = WA_LOCK + 1;
  localparam int WA_USER0 = WA_FACT0 + SEG_WORDS;
  localparam int WA_LAST  = WA_USER0 + SEG_WORDS - 1;
endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int          WA_W       = 8,
  parameter logic [63:0] FACTORY_ID = 64'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic [WA_W-1:0]   prog_wa,
  input  logic [WORD_W-1:0] prog_data,
  input  logic [WA_W-1:0]   rd_wa,
  output logic              err_range,
  output logic              err_lock,
  output logic [WORD_W-1:0] rd_word
);
  localparam int IDX_W = $clog2(SEG_WORDS);

  logic [WORD_W-1:0] lock_q;
  logic [WORD_W-1:0] user_mem [SEG_WORDS];

  function automatic region_e classify(input logic [WA_W-1:0] wa);
    if (wa == WA_W'(WA_LOCK))                                  return RG_LOCK;
    if (wa >= WA_W'(WA_FACT0) && wa < WA_W'(WA_USER0))         return RG_FACT;
    if (wa >= WA_W'(WA_USER0) && wa <= WA_W'(WA_LAST))         return RG_USER;
    return RG_NONE;
  endfunction

  region_e          prog_rg, rd_rg;
  logic [IDX_W-1:0] prog_idx, rd_uidx, rd_fidx;

  assign prog_rg  = classify(prog_wa);
  assign rd_rg    = classify(rd_wa);
  assign prog_idx = IDX_W'(prog_wa - WA_W'(WA_USER0));
  assign rd_uidx  = IDX_W'(rd_wa - WA_W'(WA_USER0));
  assign rd_fidx  = IDX_W'(rd_wa - WA_W'(WA_FACT0));

  // bit 0 of the lock word guards the factory words, bit 1 the user words
  always_comb begin
    err_range = (prog_rg == RG_NONE);
    case (prog_rg)
      RG_FACT: err_lock = !lock_q[0];
      RG_USER: err_lock = !lock_q[1];
      default: err_lock = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 16'hFFFE;
      for (int i = 0; i < SEG_WORDS; i++) user_mem[i] <= '1;
    end else if (prog_en && !err_range && !err_lock) begin
      if (prog_rg == RG_LOCK)      lock_q <= lock_q & prog_data;
      else if (prog_rg == RG_USER) user_mem[prog_idx] <= user_mem[prog_idx] & prog_data;
    end
  end

  always_comb begin
    case (rd_rg)
      RG_LOCK: rd_word = lock_q;
      RG_FACT: rd_word = FACTORY_ID[WORD_W*rd_fidx +: WORD_W];
      RG_USER: rd_word = user_mem[rd_uidx];
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
  import otp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] cmd,
  input  logic             ready,
  input  logic             err_range,
  input  logic             err_lock,
  output mode_e            mode,
  output logic             prog_en,
  output logic             sr_prog_err,
  output logic             sr_lock_err
);
  logic accept;
  assign accept  = wr_en && ready;
  assign prog_en = accept && (mode == M_SETUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= M_ARRAY;
      sr_prog_err <= 1'b0;
      sr_lock_err <= 1'b0;
    end else if (accept) begin
      if (mode == M_SETUP) begin
        mode <= M_STATUS;
        if (err_range || err_lock) sr_prog_err <= 1'b1;
        if (err_lock)              sr_lock_err <= 1'b1;
      end else begin
        case (cmd)
          CMD_IDENT: mode <= M_IDENT;
          CMD_ARRAY: mode <= M_ARRAY;
          CMD_SETUP: mode <= M_SETUP;
          CMD_CLRSR: begin
            sr_prog_err <= 1'b0;
            sr_lock_err <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_sec_ctrl.sv
module otp_sec_ctrl
  import otp_pkg::*;
#(
  parameter int          ADDR_W      = 9,
  parameter int          PROG_CYCLES = 4,
  parameter logic [63:0] FACTORY_ID  = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rdata
);
  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0]   wa;
  logic              a0_unused;
  mode_e             mode_q;
  logic              ready, prog_en, err_range, err_lock;
  logic              sr_prog_err, sr_lock_err;
  logic [WORD_W-1:0] id_word;
  logic [7:0]        status;

  assign wa        = addr[ADDR_W-1:1];
  assign a0_unused = addr[0];
  assign status    = {ready, 2'b00, sr_prog_err, 2'b00, sr_lock_err, 1'b0};

  otp_cmd_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(wdata[CMD_W-1:0]), .ready(ready),
    .err_range(err_range), .err_lock(err_lock), .mode(mode_q), .prog_en(prog_en),
    .sr_prog_err(sr_prog_err), .sr_lock_err(sr_lock_err)
  );

  otp_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(prog_en), .ready(ready)
  );

  otp_store #(.WA_W(WA_W), .FACTORY_ID(FACTORY_ID)) u_store (
    .clk(clk), .rst(rst), .prog_en(prog_en), .prog_wa(wa), .prog_data(wdata),
    .rd_wa(wa), .err_range(err_range), .err_lock(err_lock), .rd_word(id_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (mode_q)
          M_ARRAY: rdata <= '1;
          M_IDENT: rdata <= id_word;
          default: rdata <= {8'h00, status};
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_sec_ctrl_chk.sv
module otp_sec_ctrl_chk
  import otp_pkg::*;
#(
  parameter int PROG_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [CMD_W-1:0]  cmd,
  input logic [WORD_W-1:0] rdata,
  input logic              rd_valid,
  input mode_e             mode,
  input logic              ready,
  input logic              pe,
  input logic              le,
  input logic              prog_en
);
  int low_cnt;
  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= 0;
    else if (!ready) low_cnt <= low_cnt + 1;
    else            low_cnt <= 0;
  end

  a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  a_r2_array_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == M_ARRAY) |=> (rdata == 16'hFFFF));
  a_r4_prog_to_status: assert property (@(posedge clk) disable iff (rst)
    prog_en |=> (mode == M_STATUS));
  a_r6_lock_implies_prog: assert property (@(posedge clk) disable iff (rst)
    le |-> pe);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (pe && !(wr_en && cmd == CMD_CLRSR)) |=> pe);
  a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (low_cnt == PROG_CYCLES));
endmodule

bind otp_sec_ctrl otp_sec_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .cmd(wdata[7:0]),
  .rdata(rdata), .rd_valid(rd_valid), .mode(mode_q), .ready(ready),
  .pe(sr_prog_err), .le(sr_lock_err), .prog_en(prog_en)
);

// File: tb/otp_sec_ctrl_bench.sv
module otp_sec_ctrl_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          PCYC       = 4;
  localparam logic [63:0] FID        = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rd_valid;
  logic [15:0] rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_sec_ctrl #(.ADDR_W(9), .PROG_CYCLES(PCYC), .FACTORY_ID(FID)) u_otp_sec_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata)
  );

  // monitor: pop the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected rd_valid: actual rdata=%h expected no result", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] wa, input logic [15:0] d, input logic a0 = 1'b0);
    @(negedge clk); addr = {wa, a0}; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] wa, input logic [15:0] e, input string t,
                    input logic a0 = 1'b0);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); addr = {wa, a0}; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic prog(input logic [7:0] wa, input logic [15:0] d, input logic a0 = 1'b0);
    wr(8'h00, 16'h00C0);
    wr(wa, d, a0);
  endtask

  task automatic settle();
    repeat (PCYC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(8'h85, 16'hFFFF, "R1 array mode after reset");
    rd(8'h10, 16'hFFFF, "R2 array read any address");
    wr(8'h00, 16'h00C0);
    rd(8'h00, 16'h0080, "R1 status idle after reset");
    wr(8'h80, 16'hFFFF);
    settle();
    rd(8'h00, 16'h0080, "R4 status mode after program");

    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFE, "R1 lock word reset value");
    rd(8'h81, FID[15:0],  "R3 factory word 81h");
    rd(8'h84, FID[63:48], "R3 factory word 84h");
    rd(8'h88, 16'hFFFF, "R1 user word erased");
    rd(8'h89, 16'h0000, "R3 above map reads zero");
    rd(8'h7F, 16'h0000, "R3 below map reads zero");
    rd(8'h85, 16'hFFFF, "R3 A0 ignored on read", 1'b1);

    prog(8'h85, 16'h1234);
    rd(8'h00, 16'h0000, "R8 busy status right after program");
    wr(8'h00, 16'h0090);
    rd(8'h00, 16'h0080, "R8 write during busy ignored");
    wr(8'h00, 16'h0090);
    rd(8'h85, 16'h1234, "R4 programmed user word");
    prog(8'h85, 16'hFF0F);
    settle();
    wr(8'h00, 16'h0090);
    rd(8'h85, 16'h1204, "R4 program ANDs with old value");
    prog(8'h86, 16'hABCD, 1'b1);
    settle();
    wr(8'h00, 16'h0090);
    rd(8'h86, 16'hABCD, "R3 A0 ignored on program");

    prog(8'h89, 16'h0000);
    settle();
    rd(8'h00, 16'h0090, "R5 out of range sets program error only");
    wr(8'h00, 16'h0090);
    rd(8'h89, 16'h0000, "R5 out of range stores nothing");
    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h00C0);
    rd(8'h00, 16'h0090, "R9 error kept across mode changes");
    wr(8'h80, 16'hFFFF);
    settle();
    wr(8'h00, 16'h0050);
    rd(8'h00, 16'h0080, "R9 clear status and mode kept");

    prog(8'h82, 16'h0000);
    settle();
    rd(8'h00, 16'h0092, "R6 factory segment locked");
    wr(8'h00, 16'h0090);
    rd(8'h82, FID[31:16], "R6 factory word unchanged");
    wr(8'h00, 16'h0050);
    rd(8'h82, FID[31:16], "R9 clear keeps identification mode");
    wr(8'h00, 16'h0020);
    rd(8'h85, 16'h1204, "R10 unknown command ignored");

    prog(8'h80, 16'hFFFD);
    settle();
    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFC, "R7 user lock bit cleared");
    prog(8'h87, 16'h0000);
    settle();
    rd(8'h00, 16'h0092, "R6 user segment locked");
    wr(8'h00, 16'h0090);
    rd(8'h87, 16'hFFFF, "R6 locked user word unchanged");
    wr(8'h00, 16'h0050);
    prog(8'h80, 16'hFFFF);
    settle();
    rd(8'h00, 16'h0080, "R7 lock word still programmable");
    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFC, "R7 lock cannot be reversed");
    wr(8'h00, 16'h00FF);
    rd(8'h85, 16'hFFFF, "R2 return to array mode");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing results: actual pending=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule